// File: doc/BRIEF.md
# Packed SIMD Add/Subtract Unit

This unit adds or subtracts two 64-bit operands that are split into independent lanes. The lane width is chosen for each operation: eight 8-bit lanes, four 16-bit lanes, two 32-bit lanes or one 64-bit lane. A carry or borrow can travel inside a lane but never crosses from one lane to the next, so every lane gives the same answer it would give if it were computed alone.

Each lane either wraps modulo its width or clamps to the limit of its range when the result overflows. The limit depends on the signedness flag. Inputs are sampled on each rising clock edge, and the packed result appears on a registered output one cycle later. The datapath is built from a row of equal slice adders. The lane width decides, at run time, which slice boundaries pass a carry and which start a new lane.

Top module: `simd_addsub`

## Requirements
- R1: While rst_ni is low, result_o is zero, and it stays zero up to the first rising edge at which rst_ni is high.
- R2: result_o changes only on a rising clock edge and shows the result for the inputs sampled at that edge. It has a latency of one cycle and no combinational path from the inputs.
- R3: size_i selects the lane width: 0 for 8 bits, 1 for 16 bits, 2 for 32 bits and 3 for 64 bits. Lane n occupies bits [n*W +: W] of every operand and of the result.
- R4: No carry or borrow crosses a lane boundary. Each lane's result depends only on the same lane of a_i and b_i.
- R5: With sat_i low, each lane yields (a + b) mod 2^W when sub_i is 0, and (a - b) mod 2^W when sub_i is 1.
- R6: With sat_i high, signed_i low and sub_i low, a lane whose unsigned sum exceeds 2^W-1 yields all ones.
- R7: With sat_i high, signed_i low and sub_i high, a lane where b > a (unsigned) yields zero.
- R8: With sat_i high and signed_i high, a lane whose two's-complement result overflows yields 2^(W-1)-1 if the true result is positive and -2^(W-1) if it is negative.
- R9: In 64-bit lane mode, sat_i has no effect and the result always wraps.
- R10: A lane that does not overflow yields the exact sum or difference, in both wraparound and saturating modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 64 | First operand (minuend when subtracting) |
| b_i | input | 64 | Second operand (subtrahend when subtracting) |
| size_i | input | 2 | Lane width select: 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits |
| sub_i | input | 1 | 0 = add, 1 = subtract |
| sat_i | input | 1 | 1 = clamp on overflow, 0 = wrap |
| signed_i | input | 1 | 1 = two's-complement lanes, 0 = unsigned lanes |
| result_o | output | 64 | Registered packed result |

## Verification
The bench builds the unit with its default parameters: eight 8-bit slices and a 2-bit size select. With these values all four lane widths can be reached, including the full-width lane in which saturation is turned off. Directed vectors set up overflow, underflow, exact limit values and carries that stop at a lane edge. Randomized operands in every mode are then compared against a lane-by-lane reference that does its arithmetic in wide integers.

// File: rtl/simd_pkg.sv
package simd_pkg;
  typedef enum logic [1:0] {
    LANE_B8  = 2'd0,
    LANE_H16 = 2'd1,
    LANE_W32 = 2'd2,
    LANE_D64 = 2'd3
  } lane_sz_e;

  localparam int unsigned SLICE_W    = 8;
  localparam int unsigned NUM_SLICES = 8;
endpackage

// File: rtl/simd_slice_add.sv
module simd_slice_add #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W:0] full;

  assign full   = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
  assign sum_o  = full[W-1:0];
  assign cout_o = full[W];
endmodule

// File: rtl/simd_lane_map.sv
module simd_lane_map
  import simd_pkg::*;
#(
  parameter int unsigned N     = NUM_SLICES,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  lane_sz_e             size_i,
  output logic [N-1:0]         start_o,
  output logic [IDX_W-1:0]     top_idx_o [N],
  output logic                 full_o
);
  logic [31:0] mask;

  assign mask   = (32'd1 << size_i) - 32'd1;
  assign full_o = (32'd1 << size_i) >= N;

  for (genvar k = 0; k < N; k++) begin : g_map
    logic [31:0] top;
    always_comb begin
      top = 32'(k) | mask;
      if (top > N - 1) top = N - 1;
    end
    assign start_o[k]   = (32'(k) & mask) == 32'd0;
    assign top_idx_o[k] = top[IDX_W-1:0];
  end
endmodule

// File: rtl/simd_slice_sat.sv
module simd_slice_sat #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] sum_i,
  input  logic         is_top_i,
  input  logic         ovf_i,
  input  logic         hi_i,
  input  logic         signed_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    if (!ovf_i)
      res_o = sum_i;
    else if (signed_i && is_top_i)
      res_o = hi_i ? {1'b0, {(W-1){1'b1}}} : {1'b1, {(W-1){1'b0}}};
    else
      res_o = {W{hi_i}};
  end
endmodule

// File: rtl/simd_addsub.sv
module simd_addsub
  import simd_pkg::*;
#(
  parameter int unsigned SW     = SLICE_W,
  parameter int unsigned NS     = NUM_SLICES,
  localparam int unsigned DW    = SW * NS,
  localparam int unsigned IDX_W = $clog2(NS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [1:0]    size_i,
  input  logic          sub_i,
  input  logic          sat_i,
  input  logic          signed_i,
  output logic [DW-1:0] result_o
);
  lane_sz_e         size;
  logic [DW-1:0]    b_eff;
  logic [NS-1:0]    start, cin, cout, ovf_at, hi_at;
  logic [SW-1:0]    sum [NS];
  logic [IDX_W-1:0] top_idx [NS];
  logic             full;
  logic [DW-1:0]    nxt;

  assign size  = lane_sz_e'(size_i);
  assign b_eff = sub_i ? ~b_i : b_i;

  simd_lane_map #(.N(NS), .IDX_W(IDX_W)) u_map (
    .size_i   (size),
    .start_o  (start),
    .top_idx_o(top_idx),
    .full_o   (full)
  );

  for (genvar k = 0; k < NS; k++) begin : g_slice
    logic a_msb, b_msb;
    if (k == 0) begin : g_first
      assign cin[k] = sub_i;
    end else begin : g_chain
      // lane start cuts the chain and injects the subtract carry
      assign cin[k] = start[k] ? sub_i : cout[k-1];
    end

    simd_slice_add #(.W(SW)) u_add (
      .a_i   (a_i[k*SW +: SW]),
      .b_i   (b_eff[k*SW +: SW]),
      .cin_i (cin[k]),
      .sum_o (sum[k]),
      .cout_o(cout[k])
    );

    assign a_msb     = a_i[k*SW + SW - 1];
    assign b_msb     = b_eff[k*SW + SW - 1];
    // overflow and clamp direction, valid when this slice tops a lane
    assign ovf_at[k] = signed_i ? ((a_msb == b_msb) && (sum[k][SW-1] != a_msb))
                                : (cout[k] ^ sub_i);
    assign hi_at[k]  = signed_i ? ~a_msb : ~sub_i;

    simd_slice_sat #(.W(SW)) u_sat (
      .sum_i   (sum[k]),
      .is_top_i(top_idx[k] == IDX_W'(k)),
      .ovf_i   (sat_i & ~full & ovf_at[top_idx[k]]),
      .hi_i    (hi_at[top_idx[k]]),
      .signed_i(signed_i),
      .res_o   (nxt[k*SW +: SW])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) result_o <= '0;
    else         result_o <= nxt;
  end

  function automatic logic slices_ge(input logic [DW-1:0] x, input logic [DW-1:0] y);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < NS; i++)
      if (x[i*SW +: SW] < y[i*SW +: SW]) ok = 1'b0;
    return ok;
  endfunction

  a_r1_reset_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> result_o == '0);

  a_r5_slice0_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(size_i == 2'd0 && !sat_i && !sub_i)
    |-> result_o[SW-1:0] == $past(a_i[SW-1:0] + b_i[SW-1:0]));

  a_r9_full_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(size_i == 2'd3)
    |-> result_o == $past(sub_i ? a_i - b_i : a_i + b_i));

  a_r6_no_shrink: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(size_i == 2'd0 && sat_i && !signed_i && !sub_i)
    |-> slices_ge(result_o, $past(a_i)));

  a_r7_no_grow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(size_i == 2'd0 && sat_i && !signed_i && sub_i)
    |-> slices_ge($past(a_i), result_o));
endmodule

// File: tb/simd_addsub_test.sv
`timescale 1ns/1ps
module simd_addsub_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] a_i = '0, b_i = '0;
  logic [1:0]  size_i = '0;
  logic        sub_i = 1'b0, sat_i = 1'b0, signed_i = 1'b0;
  logic [63:0] result_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  simd_addsub uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .a_i(a_i), .b_i(b_i), .size_i(size_i),
    .sub_i(sub_i), .sat_i(sat_i), .signed_i(signed_i), .result_o(result_o)
  );

  typedef struct packed {
    logic [1:0]  sz;
    logic        sub, sat, sgn;
    logic [63:0] a, b, e;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 1'b0, 1'b0, 64'h0102_0304_0506_07FF, 64'h0101_0101_0101_0101, 64'h0203_0405_0607_0800},
    '{2'd0, 1'b0, 1'b1, 1'b0, 64'hFF80_7F00_FF10_2030, 64'h0180_0100_0010_2030, 64'hFFFF_8000_FF20_4060},
    '{2'd0, 1'b0, 1'b1, 1'b1, 64'h7F80_7F80_0102_FF01, 64'h0180_FF01_7F7F_FF01, 64'h7F80_7E81_7F7F_FE02},
    '{2'd0, 1'b1, 1'b1, 1'b0, 64'h0010_FF05_8000_0102, 64'h0101_0106_7F01_0202, 64'h000F_FE00_0100_0000},
    '{2'd0, 1'b1, 1'b1, 1'b1, 64'h8000_7F7F_0110_FF80, 64'h0180_FF80_0220_017F, 64'h807F_7F7F_FFF0_FE80},
    '{2'd1, 1'b0, 1'b0, 1'b0, 64'h00FF_FFFF_1234_8000, 64'h0001_0001_1111_8000, 64'h0100_0000_2345_0000},
    '{2'd1, 1'b0, 1'b1, 1'b1, 64'h7FFF_8000_7F00_1234, 64'h0001_FFFF_0100_0001, 64'h7FFF_8000_7FFF_1235},
    '{2'd2, 1'b1, 1'b1, 1'b0, 64'h0000_0001_FFFF_FFFF, 64'h0000_0002_0000_0001, 64'h0000_0000_FFFF_FFFE},
    '{2'd2, 1'b0, 1'b1, 1'b0, 64'hFFFF_FFF0_0000_FFFF, 64'h0000_0010_0000_0001, 64'hFFFF_FFFF_0001_0000},
    '{2'd3, 1'b0, 1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0000},
    '{2'd3, 1'b1, 1'b1, 1'b1, 64'h8000_0000_0000_0000, 64'h0000_0000_0000_0001, 64'h7FFF_FFFF_FFFF_FFFF},
    '{2'd2, 1'b1, 1'b0, 1'b0, 64'h0000_0000_0000_0000, 64'h0000_0001_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF}
  };

  function automatic string tag_of(logic [1:0] sz, logic sub, logic sat, logic sgn);
    if (sz == 2'd3) return "R9";
    if (!sat)       return "R5/R4";
    if (sgn)        return "R8";
    if (sub)        return "R7";
    return "R6";
  endfunction

  function automatic logic [63:0] ref_model(logic [1:0] sz, logic sub, logic sat, logic sgn,
                                            logic [63:0] a, logic [63:0] b);
    int lw, nl;
    logic [63:0] res;
    lw  = 8 << sz;
    nl  = 64 / lw;
    res = '0;
    for (int l = 0; l < nl; l++) begin
      logic signed [66:0] x, y, r, mx, mn;
      logic [63:0] m;
      m = (lw == 64) ? '1 : ((64'd1 << lw) - 64'd1);
      x = 67'((a >> (l*lw)) & m);
      y = 67'((b >> (l*lw)) & m);
      if (sgn && x[lw-1]) x = x | ~67'(m);
      if (sgn && y[lw-1]) y = y | ~67'(m);
      r = sub ? x - y : x + y;
      if (sat && lw < 64) begin
        if (sgn) begin
          mx = 67'(m >> 1);
          mn = -mx - 67'sd1;
        end else begin
          mx = 67'(m);
          mn = '0;
        end
        if (r > mx) r = mx;
        else if (r < mn) r = mn;
      end
      res = res | ((64'(r) & m) << (l*lw));
    end
    return res;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(logic [1:0] sz, logic sub, logic sat, logic sgn,
                       logic [63:0] a, logic [63:0] b);
    size_i = sz; sub_i = sub; sat_i = sat; signed_i = sgn; a_i = a; b_i = b;
  endtask

  initial begin
    // R1: reset holds zero while inputs toggle
    apply(2'd0, 1'b0, 1'b0, 1'b0, 64'h1111_2222_3333_4444, 64'h0101_0101_0101_0101);
    repeat (3) @(negedge clk_i);
    check("R1", result_o, 64'h0);
    rst_ni = 1'b1;
    #1 check("R1", result_o, 64'h0);
    @(negedge clk_i);
    check("R5/R4", result_o, 64'h1212_2323_3434_4545);

    // vector table: R3 lane encodings with every arithmetic mode
    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].sz, VECS[i].sub, VECS[i].sat, VECS[i].sgn, VECS[i].a, VECS[i].b);
      @(negedge clk_i);
      check(tag_of(VECS[i].sz, VECS[i].sub, VECS[i].sat, VECS[i].sgn), result_o, VECS[i].e);
    end

    // R2: new inputs do not reach the output before the next edge
    apply(2'd0, 1'b0, 1'b0, 1'b0, 64'h0, 64'h0);
    #1 check("R2", result_o, VECS[NV-1].e);
    @(negedge clk_i);
    check("R2", result_o, 64'h0);

    // R9: quad mode at the signed limit, saturation requested
    apply(2'd3, 1'b0, 1'b1, 1'b1, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1);
    @(negedge clk_i);
    check("R9", result_o, 64'h8000_0000_0000_0000);

    // R3/R4: same operands, different lane widths
    apply(2'd0, 1'b0, 1'b0, 1'b0, 64'h0000_FFFF_0000_00FF, 64'h0000_0001_0000_0001);
    @(negedge clk_i);
    check("R3", result_o, 64'h0000_FF00_0000_0000);
    size_i = 2'd1;
    @(negedge clk_i);
    check("R3", result_o, 64'h0000_0000_0000_0100);
    size_i = 2'd2;
    @(negedge clk_i);
    check("R3", result_o, 64'h0001_0000_0000_0100);

    // R10: exact results near the limits do not clamp
    apply(2'd1, 1'b0, 1'b1, 1'b1, 64'h7FFE_8001_0000_FFFF, 64'h0001_FFFF_7FFF_8001);
    @(negedge clk_i);
    check("R10", result_o, 64'h7FFF_8000_7FFF_8000);
    apply(2'd0, 1'b1, 1'b1, 1'b0, 64'hFF01_0000_0000_0000, 64'h0001_0000_0000_0000);
    @(negedge clk_i);
    check("R10", result_o, 64'hFF00_0000_0000_0000);

    // R4/R10: randomized operands in every mode against the lane reference
    for (int i = 0; i < 400; i++) begin
      logic [1:0]  sz;
      logic        sb, st, sg;
      logic [63:0] a, b;
      sz = 2'($urandom); sb = 1'($urandom); st = 1'($urandom); sg = 1'($urandom);
      a = {$urandom, $urandom}; b = {$urandom, $urandom};
      if (i % 4 == 0) b = ~a;
      if (i % 4 == 1) b = a;
      apply(sz, sb, st, sg, a, b);
      @(negedge clk_i);
      check("R4/R10", result_o, ref_model(sz, sb, st, sg, a, b));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule